// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block is the control sequencer of a single DMA channel. It walks a linked list of descriptors that sit in memory. Each descriptor is read with single-word memory reads, and its fields are offered to an external transfer engine. The sequencer then waits for that engine to report completion and moves on to the next descriptor. Two address registers track the walk. One holds the address of the descriptor now in progress. The other holds the address of the descriptor that will be fetched next.

Software controls the channel through a one-cycle control write.
- **Starting a chain.** While the channel is idle, software writes a non-zero head address together with the start bit.
- **Appending to a chain.** Software first patches the link word of the current tail descriptor in memory, then writes the resume bit. This works whether the channel is running or idle. The bit is acted on only at the end of a chain or while idle. At that point the sequencer re-reads the link word of the descriptor held in the current-descriptor register and continues from it. A chain that grew after its tail was fetched is therefore still followed, without restarting the channel.

The memory read port and the transfer port both use valid/ready handshakes.
- **Read request.** Once a request is raised, its valid and address are held until ready is seen.
- **Read response.** Responses carry no ready signal. The sequencer always accepts one, and never has more than one read outstanding.
- **Transfer offer.** Once a transfer is offered, its valid and fields are held until ready is seen.
- **Transfer completion.** Completion is a plain single-cycle done pulse.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the status is idle (0), no read or transfer is offered, both descriptor address registers are zero and the resume flag is clear.
- R2: A descriptor is four 32-bit words at byte offsets 0 (link), 4 (source), 8 (destination) and 12 (byte count), read in ascending offset order. Source, destination and count are then offered on the transfer port, and valid and fields are held until ready.
- R3: While a transfer is offered, the current-descriptor address equals the address the descriptor was read from, and the next-descriptor address equals its link word.
- R4: When a transfer completes with a non-zero next-descriptor address, the sequencer fetches that descriptor and offers a new transfer.
- R5: When a transfer completes with a zero next-descriptor address and the resume flag clear, the sequencer returns to idle.
- R6: When a transfer completes with a non-zero next address, the resume flag is cleared and no re-read takes place. Descriptors appended behind the tail are reached by following the tail's updated link.
- R7: When the last descriptor completes with the resume flag set, the flag is cleared. The sequencer then reads only offset 0 of the current descriptor, loads that word into the next-descriptor register, and fetches from it if it is non-zero.
- R8: A resume write while idle causes the same re-read of the current descriptor's link word, and the appended chain is followed.
- R9: A re-read that returns zero leaves the sequencer idle with the resume flag clear.
- R10: A resume write in the same cycle in which the flag is cleared leaves the flag set.
- R11: At most one memory read is outstanding. A request held off by ready keeps its valid and address stable.
- R12: Status encodes 0 idle, 1 descriptor fetch, 2 transfer (offered or running), 3 link re-read. No read or transfer is offered while idle.
- R13: A control write with start set and a non-zero address while idle loads both address registers with that address and begins a fetch there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe, one cycle |
| ctl_start | input | 1 | Start bit of the control write (honoured while idle) |
| ctl_resume | input | 1 | Resume bit of the control write |
| ctl_next_addr | input | W | Head descriptor address for a start |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | W | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | W | Read data word |
| xfer_valid | output | 1 | Transfer offered to the engine |
| xfer_ready | input | 1 | Engine accepts the offered transfer |
| xfer_src | output | W | Source address field |
| xfer_dst | output | W | Destination address field |
| xfer_len | output | W | Byte count field |
| xfer_done | input | 1 | Engine finished the accepted transfer, one-cycle pulse |
| cur_desc_addr | output | W | Current-descriptor address register |
| next_desc_addr | output | W | Next-descriptor address register |
| resume_pending | output | 1 | Resume flag |
| status | output | 2 | Channel state, encoded as in R12 |

## Verification
The checks rely on the following input rules.
- **Read responses.** The memory returns exactly one response for each accepted request, and only after acceptance.
- **Transfer completion.** The engine raises done once per accepted transfer, and only after accepting it.
- **Start writes.** A start write arrives only while the channel is idle.

The bench stays within these rules by design. Its memory model answers one cycle after each accepted request, and its engine model pulses done a fixed delay after each accepted offer. Start writes are issued only after the bench has seen the idle status. Ready on both ports toggles to exercise back-pressure. The same-cycle resume case is driven from the engine model on the exact done cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // Externally visible channel status
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_XFER   = 2'd2,
    ST_REREAD = 2'd3
  } dcs_status_e;

  // Internal sequencer state
  typedef enum logic [2:0] {
    F_IDLE,
    F_FETCH,
    F_OFFER,
    F_RUN,
    F_RR
  } dcs_fsm_e;

  localparam int DESC_WORDS = 4;

  function automatic dcs_status_e to_status(dcs_fsm_e s);
    case (s)
      F_FETCH:        return ST_FETCH;
      F_OFFER, F_RUN: return ST_XFER;
      F_RR:           return ST_REREAD;
      default:        return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dcs_rd_port.sv
// Single-outstanding word read port: request held until ready, response always taken.
module dcs_rd_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [W-1:0] issue_addr,
  output logic         req_valid,
  input  logic         req_ready,
  output logic [W-1:0] req_addr,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         done,
  output logic [W-1:0] data
);

  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      pend      <= 1'b0;
    end else begin
      if (req_valid) begin
        if (req_ready) req_valid <= 1'b0;
      end else if (!pend && issue) begin
        req_valid <= 1'b1;
        req_addr  <= issue_addr;
        pend      <= 1'b1;
      end
      if (pend && !req_valid && rsp_valid) pend <= 1'b0;
    end
  end

  assign done = pend && !req_valid && rsp_valid;
  assign data = rsp_data;

endmodule

// File: rtl/dcs_resume_flag.sv
// Resume flag: a set in the same cycle as a clear wins.
module dcs_resume_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

endmodule

// File: rtl/dcs_desc_store.sv
// Holds the words of the descriptor being fetched.
module dcs_desc_store #(
  parameter int W  = 32,
  parameter int NW = 4,
  localparam int IDXW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [W-1:0]         wr_data,
  output logic [NW-1:0][W-1:0] words
);

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                  words[g] <= '0;
      else if (wr_en && wr_idx == IDXW'(g))        words[g] <= wr_data;
    end
  end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic         ctl_start,
  input  logic         ctl_resume,
  input  logic [W-1:0] ctl_next_addr,
  output logic         rd_req_valid,
  input  logic         rd_req_ready,
  output logic [W-1:0] rd_req_addr,
  input  logic         rd_rsp_valid,
  input  logic [W-1:0] rd_rsp_data,
  output logic         xfer_valid,
  input  logic         xfer_ready,
  output logic [W-1:0] xfer_src,
  output logic [W-1:0] xfer_dst,
  output logic [W-1:0] xfer_len,
  input  logic         xfer_done,
  output logic [W-1:0] cur_desc_addr,
  output logic [W-1:0] next_desc_addr,
  output logic         resume_pending,
  output logic [1:0]   status
);

  localparam int NW       = DESC_WORDS;
  localparam int IDXW     = $clog2(NW);
  localparam int BYTE_SH  = $clog2(W / 8);

  dcs_fsm_e               fsm;
  logic [W-1:0]           cda, nda;
  logic [IDXW-1:0]        idx;
  logic                   rd_issue, rd_done;
  logic [W-1:0]           rd_issue_addr, rd_data;
  logic                   start_hit, res_set, res_clr, res_q, store_we;
  logic [NW-1:0][W-1:0]   words;

  always_comb begin
    start_hit     = (fsm == F_IDLE) && ctl_we && ctl_start && (ctl_next_addr != '0);
    rd_issue      = (fsm == F_FETCH) || (fsm == F_RR);
    rd_issue_addr = (fsm == F_RR) ? cda : cda + (W'(idx) << BYTE_SH);
    store_we      = (fsm == F_FETCH) && rd_done;
    res_set       = ctl_we && ctl_resume;
    res_clr       = ((fsm == F_IDLE) && !start_hit && res_q) ||
                    ((fsm == F_RUN) && xfer_done);
  end

  dcs_rd_port #(.W(W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (rd_issue),
    .issue_addr (rd_issue_addr),
    .req_valid  (rd_req_valid),
    .req_ready  (rd_req_ready),
    .req_addr   (rd_req_addr),
    .rsp_valid  (rd_rsp_valid),
    .rsp_data   (rd_rsp_data),
    .done       (rd_done),
    .data       (rd_data)
  );

  dcs_resume_flag u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (res_set),
    .clr   (res_clr),
    .q     (res_q)
  );

  dcs_desc_store #(.W(W), .NW(NW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_we),
    .wr_idx  (idx),
    .wr_data (rd_data),
    .words   (words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      cda <= '0;
      nda <= '0;
      idx <= '0;
    end else begin
      case (fsm)
        F_IDLE: begin
          if (start_hit) begin
            nda <= ctl_next_addr;
            cda <= ctl_next_addr;
            idx <= '0;
            fsm <= F_FETCH;
          end else if (res_q) begin
            fsm <= F_RR;
          end
        end
        F_FETCH: begin
          if (rd_done) begin
            if (idx == '0) nda <= rd_data;
            if (idx == IDXW'(NW - 1)) fsm <= F_OFFER;
            else                      idx <= idx + 1'b1;
          end
        end
        F_OFFER: begin
          if (xfer_ready) fsm <= F_RUN;
        end
        F_RUN: begin
          if (xfer_done) begin
            if (nda != '0) begin
              cda <= nda;
              idx <= '0;
              fsm <= F_FETCH;
            end else if (res_q) begin
              fsm <= F_RR;
            end else begin
              fsm <= F_IDLE;
            end
          end
        end
        F_RR: begin
          if (rd_done) begin
            nda <= rd_data;
            if (rd_data != '0) begin
              cda <= rd_data;
              idx <= '0;
              fsm <= F_FETCH;
            end else begin
              fsm <= F_IDLE;
            end
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assign xfer_valid     = (fsm == F_OFFER);
  assign xfer_src       = words[1];
  assign xfer_dst       = words[2];
  assign xfer_len       = words[3];
  assign cur_desc_addr  = cda;
  assign next_desc_addr = nda;
  assign resume_pending = res_q;
  assign status         = to_status(fsm);

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_we,
  input logic         ctl_resume,
  input logic         rd_req_valid,
  input logic         rd_req_ready,
  input logic [W-1:0] rd_req_addr,
  input logic         xfer_valid,
  input logic         xfer_ready,
  input logic [W-1:0] xfer_src,
  input logic [W-1:0] xfer_dst,
  input logic [W-1:0] xfer_len,
  input logic [W-1:0] cur_desc_addr,
  input logic         resume_pending,
  input logic [1:0]   status
);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r2_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_src)
                                  && $stable(xfer_dst) && $stable(xfer_len));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd0 |-> !rd_req_valid && !xfer_valid);

  a_r10_resume_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_resume |=> resume_pending);

  a_r7_reread_addr: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd3 && rd_req_valid |-> rd_req_addr == cur_desc_addr);

  a_r3_cur_valid: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> cur_desc_addr != '0);

  a_r12_xfer_status: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> status == 2'd2);

endmodule

bind dma_chain_seq dcs_checker #(.W(W)) u_dcs_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_we         (ctl_we),
  .ctl_resume     (ctl_resume),
  .rd_req_valid   (rd_req_valid),
  .rd_req_ready   (rd_req_ready),
  .rd_req_addr    (rd_req_addr),
  .xfer_valid     (xfer_valid),
  .xfer_ready     (xfer_ready),
  .xfer_src       (xfer_src),
  .xfer_dst       (xfer_dst),
  .xfer_len       (xfer_len),
  .cur_desc_addr  (cur_desc_addr),
  .resume_pending (resume_pending),
  .status         (status)
);

// File: tb/tb_dma_chain_seq.sv
`timescale 1ns/1ps
module tb_dma_chain_seq;

  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] cur;
    logic [W-1:0] link;
    logic [W-1:0] src;
    logic [W-1:0] dst;
    logic [W-1:0] len;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic drv_we = 0, drv_start = 0, drv_res = 0;
  logic eng_we = 0, eng_res = 0;
  logic [W-1:0] ctl_next_addr = '0;
  logic ctl_we, ctl_resume;
  assign ctl_we     = drv_we | eng_we;
  assign ctl_resume = drv_res | eng_res;

  logic rd_req_valid, rd_req_ready = 0;
  logic [W-1:0] rd_req_addr;
  logic rd_rsp_valid = 0;
  logic [W-1:0] rd_rsp_data = '0;
  logic xfer_valid, xfer_ready = 0, xfer_done = 0;
  logic [W-1:0] xfer_src, xfer_dst, xfer_len, cur_desc_addr, next_desc_addr;
  logic resume_pending;
  logic [1:0] status;

  dma_chain_seq #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(drv_start),
    .ctl_resume(ctl_resume), .ctl_next_addr(ctl_next_addr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .cur_desc_addr(cur_desc_addr), .next_desc_addr(next_desc_addr),
    .resume_pending(resume_pending), .status(status)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] mem [64];
  int rdcnt [64];
  exp_t exp_q [$];
  int xfers_seen = 0;
  logic [3:0] seen_status = '0;
  int cyc = 0;
  logic res_arm = 0, res_used = 0;
  logic eng_busy = 0;
  int eng_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and ready patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_req_ready <= (cyc % 3) != 0;
    xfer_ready   <= (cyc % 4) >= 2;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[7:2]];
      rdcnt[rd_req_addr[7:2]] <= rdcnt[rd_req_addr[7:2]] + 1;
    end else begin
      rd_rsp_valid <= 1'b0;
    end
  end

  // transfer engine model
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    eng_we    <= 1'b0;
    eng_res   <= 1'b0;
    if (eng_busy) begin
      if (eng_cnt == 0) begin
        xfer_done <= 1'b1;
        eng_busy  <= 1'b0;
        if (res_arm && !res_used) begin
          eng_we   <= 1'b1;
          eng_res  <= 1'b1;
          res_used <= 1'b1;
        end
      end else eng_cnt <= eng_cnt - 1;
    end else if (xfer_valid && xfer_ready) begin
      eng_busy <= 1'b1;
      eng_cnt  <= 4;
    end
  end

  // monitor: scoreboard compare on each accepted transfer
  always @(negedge clk) begin
    if (rst_n) begin
      seen_status[status] <= 1'b1;
      if (xfer_valid && xfer_ready) begin
        xfers_seen <= xfers_seen + 1;
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected transfer src", xfer_src, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(xfer_src == e.src && xfer_dst == e.dst && xfer_len == e.len,
              "R2", "transfer fields (src)", xfer_src, e.src);
          chk(cur_desc_addr == e.cur && next_desc_addr == e.link,
              "R3", "cur/next address (cur)", cur_desc_addr, e.cur);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run timed out", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic put_desc(input logic [W-1:0] a, input logic [W-1:0] link);
    mem[a[7:2]]     = link;
    mem[a[7:2] + 1] = 32'h1000_0000 | a;
    mem[a[7:2] + 2] = 32'h2000_0000 | a;
    mem[a[7:2] + 3] = a + 8;
  endtask

  task automatic expect_xfer(input logic [W-1:0] a, input logic [W-1:0] link);
    exp_t e;
    e.cur = a; e.link = link;
    e.src = 32'h1000_0000 | a; e.dst = 32'h2000_0000 | a; e.len = a + 8;
    exp_q.push_back(e);
  endtask

  task automatic ctl_write(input bit st, input bit res, input logic [W-1:0] a);
    @(negedge clk);
    drv_we = 1; drv_start = st; drv_res = res; ctl_next_addr = a;
    @(negedge clk);
    drv_we = 0; drv_start = 0; drv_res = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (status != 2'd0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_xfers(input int n);
    while (xfers_seen < n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; rdcnt[i] = 0; end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(status == 2'd0, "R1", "reset status", W'(status), 0);
    chk(!rd_req_valid && !xfer_valid, "R1", "reset offers", W'({rd_req_valid, xfer_valid}), 0);
    chk(cur_desc_addr == 0 && next_desc_addr == 0, "R1", "reset addresses", cur_desc_addr | next_desc_addr, 0);
    chk(!resume_pending, "R1", "reset resume", W'(resume_pending), 0);
    rst_n = 1;

    // R13 R4 R5: chain A(0x10) -> B(0x20) -> end
    put_desc(32'h10, 32'h20);
    put_desc(32'h20, 32'h0);
    expect_xfer(32'h10, 32'h20);
    expect_xfer(32'h20, 32'h0);
    ctl_write(1, 0, 32'h10);
    chk(next_desc_addr == 32'h10 && cur_desc_addr == 32'h10, "R13", "start load", next_desc_addr, 32'h10);
    wait_idle();
    chk(status == 2'd0, "R5", "idle after zero link", W'(status), 0);
    chk(rdcnt[4] == 1 && rdcnt[5] == 1 && rdcnt[6] == 1 && rdcnt[7] == 1, "R2",
        "four words read once", W'(rdcnt[7]), 1);

    // R8: append C(0x30) while idle, resume write
    put_desc(32'h30, 32'h0);
    mem[32'h20 >> 2] = 32'h30;
    expect_xfer(32'h30, 32'h0);
    ctl_write(0, 1, '0);
    wait_idle();
    chk(rdcnt[8] == 2, "R8", "tail link re-read", W'(rdcnt[8]), 2);
    chk(rdcnt[9] == 1, "R7", "re-read touches offset 0 only", W'(rdcnt[9]), 1);
    chk(!resume_pending, "R9", "resume cleared", W'(resume_pending), 0);

    // R6: resume during non-last transfer is dropped
    put_desc(32'h40, 32'h50);
    put_desc(32'h50, 32'h0);
    expect_xfer(32'h40, 32'h50);
    expect_xfer(32'h50, 32'h0);
    ctl_write(1, 0, 32'h40);
    wait_xfers(4);
    ctl_write(0, 1, '0);
    wait_idle();
    chk(rdcnt[20] == 1, "R6", "no re-read of tail", W'(rdcnt[20]), 1);
    chk(!resume_pending, "R6", "resume cleared at non-last done", W'(resume_pending), 0);

    // R10 R7 R9: resume written on the exact done cycle of a non-last descriptor
    put_desc(32'h60, 32'h70);
    put_desc(32'h70, 32'h0);
    expect_xfer(32'h60, 32'h70);
    expect_xfer(32'h70, 32'h0);
    res_arm = 1;
    ctl_write(1, 0, 32'h60);
    wait_idle();
    chk(rdcnt[28] == 2, "R10", "same-cycle resume kept, tail re-read", W'(rdcnt[28]), 2);
    chk(status == 2'd0 && !resume_pending, "R9", "zero re-read returns idle", W'(resume_pending), 0);
    chk(next_desc_addr == 0, "R9", "next register from re-read", next_desc_addr, 0);

    // R7: tail patched and resume set while its transfer runs
    put_desc(32'h80, 32'h0);
    put_desc(32'h90, 32'h0);
    expect_xfer(32'h80, 32'h0);
    expect_xfer(32'h90, 32'h0);
    ctl_write(1, 0, 32'h80);
    wait_xfers(8);
    mem[32'h80 >> 2] = 32'h90;
    ctl_write(0, 1, '0);
    wait_idle();
    chk(rdcnt[32] == 2, "R7", "tail re-read after active append", W'(rdcnt[32]), 2);
    chk(cur_desc_addr == 32'h90, "R7", "appended descriptor current", cur_desc_addr, 32'h90);

    // R9: idle resume with nothing appended
    ctl_write(0, 1, '0);
    wait_idle();
    chk(rdcnt[36] == 2 && xfers_seen == 9, "R9", "idle re-read of zero link", W'(rdcnt[36]), 2);

    chk(exp_q.size() == 0, "R4", "all expected transfers seen", W'(exp_q.size()), 0);
    chk(seen_status == 4'hF, "R12", "all status codes observed", W'(seen_status), 4'hF);
    chk(rdcnt[0] == 0, "R11", "no stray read at zero", W'(rdcnt[0]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule